// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a set of hardware event lines and presents one interrupt request to a processor. Every source has an enable bit and a 4-bit level. Level 0 keeps a source permanently silent, level 1 is the weakest and level 15 the strongest. Any number of sources may share a level. An event pulse sets a sticky pending flag. The controller then offers the strongest eligible pending source, together with its index and level.

When the processor takes the request, it pulses `cpu_ack`. The controller then clears that source's pending flag and pushes the source's level onto a stack of in-service levels. The top of that stack is the threshold, and only a strictly stronger pending source can raise a new request over it. That new request nests inside the current handler. When a handler finishes, the processor pulses `cpu_eoi`. The stack pops, and the earlier threshold returns, so weaker work that waited becomes eligible again.

Configuration uses a plain write port. One write sets both the enable and the level of the selected source.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, `irq_id` is 0, `irq_level` is 0 and `svc_level` is 0. Every source is disabled at level 0 with nothing pending. Whenever `irq_req` is 0, `irq_id` and `irq_level` are 0.
- R2: A source contributes to arbitration only when its enable bit is 1 and its level is nonzero. Its pending flag is kept while it is disabled or at level 0, so enabling it later raises the request.
- R3: Among eligible pending sources, the one with the highest level is offered. Ties at that level go to the lowest source index. `irq_id` carries the index and `irq_level` carries the level.
- R4: A `src_pulse` bit sets that source's pending flag, and the flag stays set until that source is acknowledged. A pulse in the same cycle as its own acknowledge leaves the flag set.
- R5: The request outputs are registered. A change of pending state, configuration or threshold at a clock edge appears on the outputs at the following edge.
- R6: `cpu_ack` while `irq_req` is 1 pushes `irq_level` onto the in-service stack, so `svc_level` becomes that level one cycle later. The same edge drops `irq_req` for at least one cycle.
- R7: A request is raised only when the winner's level is strictly greater than `svc_level`. A pending source at the same or a lower level stays waiting.
- R8: `cpu_eoi` pops the stack, so `svc_level` returns to the level that was in service before. When the stack becomes empty, `svc_level` returns to 0. Waiting weaker sources are then offered.
- R9: `cpu_eoi` with an empty stack and `cpu_ack` while `irq_req` is 0 have no effect. When both strobes are accepted in one cycle, the pop happens before the push.
- R10: When `cfg_we` is 1, `cfg_en` and `cfg_prio` are written into the source chosen by `cfg_sel`. An index at or above the source count is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | ID_W (4) | Source index to configure |
| cfg_en | input | 1 | Enable value written |
| cfg_prio | input | PRIO_W (4) | Level written, 0 silences the source |
| src_pulse | input | NUM_SRC (16) | Event pulses, one per source |
| cpu_ack | input | 1 | Processor takes the current request |
| cpu_eoi | input | 1 | Processor finished the innermost handler |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_id | output | ID_W (4) | Index of the offered source |
| irq_level | output | PRIO_W (4) | Level of the offered source |
| svc_level | output | PRIO_W (4) | Level currently in service, 0 when idle |

## Verification
The bench targets several corner cases:
- Ties between sources at the same level. A reversed or unstable scan would offer the higher index.
- Same-level events that arrive during service. A `>=` threshold compare would re-raise the request.
- A pulse that coincides with its own acknowledge. A clear-wins flag would lose that event.
- An end-of-service strobe on an empty stack, which would underflow the pointer and corrupt later thresholds.
- An acknowledge while no request is up, which would push a level of 0 onto the stack.
- A source that pulses while disabled or at level 0 and is enabled afterwards. It must still be served.

Long random runs with nested acknowledges and pops compare every output in every cycle against a bench model. A stale request after an acknowledge would show up there as a double push.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

   // Stack operation, encoded as {pop, push}
   typedef enum logic [1:0] {
      STK_HOLD = 2'b00,
      STK_PUSH = 2'b01,
      STK_POP  = 2'b10,
      STK_SWAP = 2'b11
   } stk_op_e;

   // Index width for n items, never below one bit
   function automatic int unsigned idx_w(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned ID_W    = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [ID_W-1:0]           cfg_sel,
   input  logic                      cfg_en,
   input  logic [PRIO_W-1:0]         cfg_prio,
   input  logic [NUM_SRC-1:0]        src_pulse,
   input  logic                      clr_en,
   input  logic [ID_W-1:0]           clr_id,
   output logic [NUM_SRC-1:0]        eligible,
   output logic [NUM_SRC*PRIO_W-1:0] prio_flat
);

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic              pend_q;
      logic              en_q;
      logic [PRIO_W-1:0] prio_q;
      logic              cfg_hit;
      logic              clr_hit;

      assign cfg_hit = cfg_we && (cfg_sel == ID_W'(g));
      assign clr_hit = clr_en && (clr_id == ID_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
            en_q   <= 1'b0;
            prio_q <= '0;
         end else begin
            // a fresh pulse wins over a clear in the same cycle
            pend_q <= src_pulse[g] | (pend_q & ~clr_hit);
            if (cfg_hit) begin
               en_q   <= cfg_en;
               prio_q <= cfg_prio;
            end
         end
      end

      assign eligible[g] = pend_q & en_q & (prio_q != '0);
      assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
   end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned ID_W    = 4
) (
   input  logic [NUM_SRC-1:0]        eligible,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
   input  logic [PRIO_W-1:0]         threshold,
   output logic                      win_valid,
   output logic [ID_W-1:0]           win_id,
   output logic [PRIO_W-1:0]         win_lvl
);

   logic found;

   // descending scan with >= lets the lower index take ties
   always_comb begin
      found   = 1'b0;
      win_id  = '0;
      win_lvl = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (eligible[i] && (prio_flat[i*PRIO_W +: PRIO_W] >= win_lvl)) begin
            found   = 1'b1;
            win_id  = ID_W'(i);
            win_lvl = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
      win_valid = found && (win_lvl > threshold);
   end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
   import irq_nest_pkg::*;
#(
   parameter int unsigned PRIO_W = 4,
   parameter int unsigned DEPTH  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  stk_op_e           op,
   input  logic [PRIO_W-1:0] push_lvl,
   output logic [PRIO_W-1:0] top_lvl,
   output logic              empty
);

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam int unsigned IDX_W = idx_w(DEPTH);

   logic [PRIO_W-1:0] mem [DEPTH];
   logic [CNT_W-1:0]  count_q;
   logic [CNT_W-1:0]  wr_idx;
   logic              wr_en;

   assign wr_en  = (op == STK_PUSH) || (op == STK_SWAP);
   assign wr_idx = (op == STK_SWAP) ? (count_q - 1'b1) : count_q;
   assign empty  = (count_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         for (int e = 0; e < int'(DEPTH); e++) mem[e] <= '0;
      end else begin
         for (int e = 0; e < int'(DEPTH); e++) begin
            if (wr_en && (wr_idx == CNT_W'(e))) mem[e] <= push_lvl;
         end
         case (op)
            STK_PUSH: count_q <= count_q + 1'b1;
            STK_POP:  count_q <= count_q - 1'b1;
            default:  count_q <= count_q;
         endcase
      end
   end

   assign top_lvl = empty ? '0 : mem[IDX_W'(count_q - 1'b1)];

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
   import irq_nest_pkg::*;
#(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned PRIO_W  = 4,
   localparam int unsigned ID_W   = idx_w(NUM_SRC),
   localparam int unsigned LVLS   = (1 << PRIO_W) - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [ID_W-1:0]    cfg_sel,
   input  logic               cfg_en,
   input  logic [PRIO_W-1:0]  cfg_prio,
   input  logic [NUM_SRC-1:0] src_pulse,
   input  logic               cpu_ack,
   input  logic               cpu_eoi,
   output logic               irq_req,
   output logic [ID_W-1:0]    irq_id,
   output logic [PRIO_W-1:0]  irq_level,
   output logic [PRIO_W-1:0]  svc_level
);

   if (NUM_SRC < 2) begin : g_bad_src
      $error("irq_nest_ctrl: NUM_SRC must be at least 2");
   end
   if ((PRIO_W < 1) || (PRIO_W > 8)) begin : g_bad_prio
      $error("irq_nest_ctrl: PRIO_W must lie in 1..8");
   end

   logic [NUM_SRC-1:0]        eligible;
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic                      win_valid;
   logic [ID_W-1:0]           win_id;
   logic [PRIO_W-1:0]         win_lvl;
   logic                      stk_empty;
   logic                      ack_ok;
   logic                      eoi_ok;
   logic                      req_d;
   stk_op_e                   stk_op;

   logic                      req_q;
   logic [ID_W-1:0]           id_q;
   logic [PRIO_W-1:0]         lvl_q;

   assign ack_ok = cpu_ack & req_q;
   assign eoi_ok = cpu_eoi & ~stk_empty;
   assign stk_op = stk_op_e'({eoi_ok, ack_ok});

   irq_src_bank #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .ID_W    (ID_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_en    (cfg_en),
      .cfg_prio  (cfg_prio),
      .src_pulse (src_pulse),
      .clr_en    (ack_ok),
      .clr_id    (id_q),
      .eligible  (eligible),
      .prio_flat (prio_flat)
   );

   irq_arbiter #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .ID_W    (ID_W)
   ) u_arb (
      .eligible  (eligible),
      .prio_flat (prio_flat),
      .threshold (svc_level),
      .win_valid (win_valid),
      .win_id    (win_id),
      .win_lvl   (win_lvl)
   );

   irq_level_stack #(
      .PRIO_W (PRIO_W),
      .DEPTH  (LVLS)
   ) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (stk_op),
      .push_lvl (lvl_q),
      .top_lvl  (svc_level),
      .empty    (stk_empty)
   );

   // an accepted acknowledge hides the request for one cycle so a stale
   // winner cannot be taken twice
   assign req_d = win_valid & ~ack_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         id_q  <= '0;
         lvl_q <= '0;
      end else begin
         req_q <= req_d;
         id_q  <= req_d ? win_id  : '0;
         lvl_q <= req_d ? win_lvl : '0;
      end
   end

   assign irq_req   = req_q;
   assign irq_id    = id_q;
   assign irq_level = lvl_q;

endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
   parameter int unsigned ID_W   = 4,
   parameter int unsigned PRIO_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ack,
   input logic              cpu_eoi,
   input logic              irq_req,
   input logic [ID_W-1:0]   irq_id,
   input logic [PRIO_W-1:0] irq_level,
   input logic [PRIO_W-1:0] svc_level
);

   // R1
   idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (irq_id == '0) && (irq_level == '0));

   // R2
   req_level_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_level != '0));

   // R7
   req_above_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_level > svc_level));

   // R6
   ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && cpu_ack) |=> !irq_req);

   // R6
   ack_pushes_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && cpu_ack && !cpu_eoi) |=> (svc_level == $past(irq_level)));

   // R9
   svc_rise_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_req && cpu_ack) |=> (svc_level <= $past(svc_level)));

   // R8
   eoi_lowers_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_eoi && (svc_level != '0) && !(irq_req && cpu_ack)) |=> (svc_level < $past(svc_level)));

endmodule

bind irq_nest_ctrl irq_nest_chk #(
   .ID_W   (ID_W),
   .PRIO_W (PRIO_W)
) u_irq_nest_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_ack   (cpu_ack),
   .cpu_eoi   (cpu_eoi),
   .irq_req   (irq_req),
   .irq_id    (irq_id),
   .irq_level (irq_level),
   .svc_level (svc_level)
);

// File: tb/tb_irq_nest_ctrl.sv
`timescale 1ns/1ps
module tb_irq_nest_ctrl;

   localparam int NS = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [3:0]    cfg_sel = '0;
   logic          cfg_en = 1'b0;
   logic [3:0]    cfg_prio = '0;
   logic [NS-1:0] src_pulse = '0;
   logic          cpu_ack = 1'b0;
   logic          cpu_eoi = 1'b0;
   logic          irq_req;
   logic [3:0]    irq_id;
   logic [3:0]    irq_level;
   logic [3:0]    svc_level;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model state
   bit m_pend [NS];
   bit m_en   [NS];
   int m_prio [NS];
   int m_stk  [16];
   int m_cnt = 0;
   bit m_req = 0;
   int m_id = 0;
   int m_lvl = 0;

   always #2 clk = ~clk;

   irq_nest_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_en(cfg_en), .cfg_prio(cfg_prio), .src_pulse(src_pulse),
      .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi), .irq_req(irq_req),
      .irq_id(irq_id), .irq_level(irq_level), .svc_level(svc_level)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int top_lvl();
      return (m_cnt == 0) ? 0 : m_stk[m_cnt-1];
   endfunction

   // R3: highest level wins, ties to the lowest index; R7: strict compare
   function automatic void arbitrate(output bit v, output int id, output int lvl);
      lvl = 0; id = 0; v = 0;
      for (int i = 0; i < NS; i++) begin
         if (m_pend[i] && m_en[i] && m_prio[i] != 0 && m_prio[i] > lvl) begin
            lvl = m_prio[i]; id = i;
         end
      end
      if (lvl > top_lvl()) v = 1;
      else begin id = 0; lvl = 0; end
   endfunction

   // drive one cycle of inputs, advance the model, compare at the next negedge
   task automatic step(input logic [NS-1:0] pulse, input bit ack, input bit eoi,
                       input bit we, input int sel, input bit en, input int pr);
      bit v; int bid; int blvl; bit ack_ok; bit eoi_ok;
      src_pulse = pulse; cpu_ack = ack; cpu_eoi = eoi;
      cfg_we = we; cfg_sel = 4'(sel); cfg_en = en; cfg_prio = 4'(pr);
      arbitrate(v, bid, blvl);
      ack_ok = ack && m_req;
      eoi_ok = eoi && (m_cnt > 0);
      if (ack_ok) m_pend[m_id] = 0;
      for (int i = 0; i < NS; i++) if (pulse[i]) m_pend[i] = 1;
      if (we && sel < NS) begin m_en[sel] = en; m_prio[sel] = pr; end
      if (eoi_ok) m_cnt--;
      if (ack_ok) begin m_stk[m_cnt] = m_lvl; m_cnt++; end
      m_req = v && !ack_ok;
      m_id  = m_req ? bid : 0;
      m_lvl = m_req ? blvl : 0;
      @(negedge clk);
      chk("R7 irq_req", int'(irq_req), int'(m_req));
      chk("R3 irq_id", int'(irq_id), m_id);
      chk("R3 irq_level", int'(irq_level), m_lvl);
      chk("R8 svc_level", int'(svc_level), top_lvl());
   endtask

   task automatic idle(); step('0, 0, 0, 0, 0, 0, 0); endtask
   task automatic cfg(input int sel, input bit en, input int pr);
      step('0, 0, 0, 1, sel, en, pr);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      for (int i = 0; i < NS; i++) begin m_pend[i] = 0; m_en[i] = 0; m_prio[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq_req", int'(irq_req), 0);
      chk("R1 irq_id", int'(irq_id), 0);
      chk("R1 irq_level", int'(irq_level), 0);
      chk("R1 svc_level", int'(svc_level), 0);

      // R10 configuration writes
      cfg(3, 1, 5); cfg(7, 1, 5); cfg(9, 1, 0); cfg(12, 0, 9);
      // R2 level 0 source never requests
      step(NS'(1) << 9, 0, 0, 0, 0, 0, 0); idle();
      chk("R2 level0 silent", int'(irq_req), 0);
      // R2 disabled source keeps pending and is served once enabled
      step(NS'(1) << 12, 0, 0, 0, 0, 0, 0); idle();
      chk("R2 masked silent", int'(irq_req), 0);
      cfg(12, 1, 9);
      // R5 one cycle after the write the request rises
      chk("R5 not yet", int'(irq_req), 0);
      idle();
      chk("R2 sticky served", int'(irq_id), 12);
      // R9 eoi on empty stack has no effect
      step('0, 0, 1, 0, 0, 0, 0);
      chk("R9 empty eoi", int'(svc_level), 0);
      // R6 acknowledge
      step('0, 1, 0, 0, 0, 0, 0);
      chk("R6 req drops", int'(irq_req), 0);
      chk("R6 svc level", int'(svc_level), 9);
      // R7 same/lower level waits
      step((NS'(1) << 3) | (NS'(1) << 7), 0, 0, 0, 0, 0, 0); idle(); idle();
      chk("R7 lower waits", int'(irq_req), 0);
      cfg(5, 1, 9); step(NS'(1) << 5, 0, 0, 0, 0, 0, 0); idle();
      chk("R7 equal waits", int'(irq_req), 0);
      // R7 strictly higher pre-empts
      cfg(14, 1, 13); step(NS'(1) << 14, 0, 0, 0, 0, 0, 0); idle();
      chk("R7 preempt", int'(irq_id), 14);
      // R4 pulse in the same cycle as its own ack keeps it pending
      step(NS'(1) << 14, 1, 0, 0, 0, 0, 0);
      chk("R6 nested svc", int'(svc_level), 13);
      // R8 pop restores 9, source 14 (13) pending again -> request
      step('0, 0, 1, 0, 0, 0, 0);
      chk("R8 restore", int'(svc_level), 9);
      idle();
      chk("R4 repulse kept", int'(irq_id), 14);
      // R9 ack plus eoi in one cycle: pop 9 then push 13
      step('0, 1, 1, 0, 0, 0, 0);
      chk("R9 swap", int'(svc_level), 13);
      step('0, 0, 1, 0, 0, 0, 0); idle();
      // R3 level 9 source 5 beats level 5; after it, tie 3 vs 7 -> 3
      chk("R3 highest", int'(irq_id), 5);
      step('0, 1, 0, 0, 0, 0, 0); step('0, 0, 1, 0, 0, 0, 0); idle();
      chk("R3 tie low index", int'(irq_id), 3);
      // R9 ack with no request ignored
      step('0, 1, 0, 0, 0, 0, 0); step('0, 0, 1, 0, 0, 0, 0);
      step('0, 1, 0, 0, 0, 0, 0);
      idle(); idle();
      chk("R9 stray ack", int'(svc_level), 0);
      // R10 out of range select is absent here (16 sources fill the index)

      // random phase
      for (int i = 0; i < NS; i++) cfg(i, ($urandom % 5) != 0, $urandom % 16);
      for (int c = 0; c < 4000; c++) begin
         logic [NS-1:0] p;
         bit a; bit e; bit w;
         p = NS'($urandom & $urandom & $urandom & $urandom);
         a = m_req ? (($urandom % 2) == 0) : (($urandom % 16) == 0);
         e = (($urandom % 6) == 0);
         w = (($urandom % 25) == 0);
         step(p, a, e, w, $urandom % NS, ($urandom % 4) != 0, $urandom % 16);
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule